// File: doc/BRIEF.md
# Security-banked configuration control register

This block is one register slice of a processor's memory-mapped system control space. It holds a configuration control word in two copies, one for the Secure world and one for the Non-secure world. Each bus access picks its copy with the access's secure attribute. One bit, the fault-ignore flag (bit 8), is not banked. It is stored only in the Non-secure copy. Reads from either world merge it in, and Secure writes split it out. On a v8 profile (parameter `V8_PROFILE`), two bits are reserved-as-one and are forced to 1 in every stored value.

The slice also decides whether unprivileged accesses to the control space are allowed. An unprivileged access is refused with a bus error unless it targets the software trigger register. That register accepts an unprivileged access only when the user-trigger enable bit is set in the copy that the access selects. An accepted write to the trigger register sends a one-cycle pending pulse that carries an interrupt number. The slice also holds the memory-management handler's active flag. The register bus is a single-cycle strobe interface. Every access gets a registered response one clock later.

Top module: `sec_cfg_ctrl`

## Requirements
- R1: Offset 0xD14 holds two copies of the configuration word. An access with `bus_secure`=1 reads or writes the Secure copy, and an access with `bus_secure`=0 uses the Non-secure copy.
- R2: Every read of 0xD14 returns the selected copy with bit 8 (fault-ignore) taken from the Non-secure copy, so both worlds read the same bit 8.
- R3: A Secure write to 0xD14 stores its bit 8 into the Non-secure copy and leaves that copy's other bits unchanged. It then stores the value into the Secure copy with bit 8 cleared. A Non-secure write stores the whole shaped value, bit 8 included, into the Non-secure copy.
- R4: Only bits 0 (any-level thread entry), 1 (user trigger enable), 3 (unaligned trap), 4 (divide-by-zero trap), 8 (fault-ignore) and 9 (stack alignment) can be written. All other bits of 0xD14 read as 0.
- R5: With `V8_PROFILE`=1 (the default), bits 0 and 9 are forced to 1 in every written value, and both copies reset to 0x201. With `V8_PROFILE`=0, both copies reset to 0x200.
- R6: A read or write with `bus_user`=1 to any offset other than 0xF00 gets an error response and changes no state.
- R7: An access with `bus_user`=1 to 0xF00 is accepted only when bit 1 of the copy chosen by `bus_secure` is set. Otherwise it gets an error response, changes nothing, and sends no trigger pulse.
- R8: An accepted write to 0xF00 drives `trig_valid` high for exactly the response cycle, with `trig_irq` equal to write-data bits [8:0]. At all other times `trig_valid` is 0.
- R9: An accepted write to 0xD24 sets the memory-management handler active flag from write-data bit 0. A read of 0xD24 returns the flag in bit 0 and zeros elsewhere.
- R10: Each strobe gets a response one cycle later: `rsp_valid` is high for that one cycle. `rsp_rdata` is 0 for writes, errors, the trigger register and unmapped offsets. If both strobes are high, the access is a write. After reset, `rsp_valid`, `rsp_err` and `trig_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the system control space |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_secure | input | 1 | Access security attribute (1 = Secure) |
| bus_user | input | 1 | Access privilege attribute (1 = unprivileged) |
| rsp_valid | output | 1 | Response valid, one cycle after a strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response for a denied access |
| trig_valid | output | 1 | Software trigger pending pulse |
| trig_irq | output | 9 | Interrupt number carried by the pulse |

## Verification
Every strobe driven before a rising edge gets its response, and any trigger pulse, in the cycle that this edge starts, with exactly one register on the way. A register change made by a write is visible to an access strobed in the next cycle. The driver applies one access per cycle and queues the expected response. The monitor samples a quarter period after each rising edge and pops one item each time `rsp_valid` is seen. A response with no queued item, a stray trigger pulse, or items left unconsumed once the bus is idle all count as mismatches. Back-to-back accesses check that state written in one cycle is used by the permission check and read path of the next.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int BUS_W     = 32;
  localparam int NUM_BANKS = 2;
  localparam int BANK_NS   = 0;
  localparam int BANK_S    = 1;

  // field positions inside the configuration word
  localparam int F_THR_ANY  = 0;
  localparam int F_USR_TRIG = 1;
  localparam int F_UNALN    = 3;
  localparam int F_DIVZ     = 4;
  localparam int F_FIGN     = 8;
  localparam int F_STK      = 9;

  typedef logic [BUS_W-1:0] word_t;

  function automatic word_t bit_at(input int pos);
    return word_t'(1) << pos;
  endfunction

  function automatic word_t cfg_write_mask();
    return bit_at(F_THR_ANY) | bit_at(F_USR_TRIG) | bit_at(F_UNALN) |
           bit_at(F_DIVZ) | bit_at(F_FIGN) | bit_at(F_STK);
  endfunction

  function automatic word_t cfg_shared_mask();
    return bit_at(F_FIGN);
  endfunction

  function automatic word_t cfg_forced(input bit v8);
    return v8 ? (bit_at(F_THR_ANY) | bit_at(F_STK)) : '0;
  endfunction

  function automatic word_t cfg_reset(input bit v8);
    return bit_at(F_STK) | cfg_forced(v8);
  endfunction

  // write value after masking and reserved-as-one forcing
  function automatic word_t cfg_shape(input word_t w, input bit v8);
    return (w & cfg_write_mask()) | cfg_forced(v8);
  endfunction

  // value seen by a read: selected copy plus the shared bit from NS
  function automatic word_t cfg_view(input word_t sel, input word_t ns);
    return (sel & ~cfg_shared_mask()) | (ns & cfg_shared_mask());
  endfunction

endpackage

// File: rtl/cfgbank_gate.sv
module cfgbank_gate #(
  parameter int               ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] TRIG_OFS = 12'hF00
) (
  input  logic              strobe_wr,
  input  logic              strobe_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              user,
  input  logic              sel_usr_trig,
  output logic              acc_any,
  output logic              acc_ok,
  output logic              acc_deny
);

  logic at_trig;
  logic user_pass;

  assign acc_any   = strobe_wr | strobe_rd;
  assign at_trig   = (addr == TRIG_OFS);
  assign user_pass = at_trig & sel_usr_trig;
  assign acc_ok    = acc_any & (~user | user_pass);
  assign acc_deny  = acc_any & user & ~user_pass;

endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store
  import cfgbank_pkg::*;
#(
  parameter bit V8_PROFILE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_cfg,
  input  logic  wr_secure,
  input  word_t wdata,
  output word_t cp_ns,
  output word_t cp_s
);

  word_t wval;
  word_t bank_q [NUM_BANKS];

  assign wval = cfg_shape(wdata, V8_PROFILE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    word_t cur_q;
    word_t nxt;

    always_comb begin
      nxt = cur_q;
      if (wr_cfg) begin
        if (b == BANK_NS) begin
          if (wr_secure)
            nxt = (cur_q & ~cfg_shared_mask()) | (wval & cfg_shared_mask());
          else
            nxt = wval;
        end else if (wr_secure) begin
          nxt = wval & ~cfg_shared_mask();
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= cfg_reset(V8_PROFILE);
      else        cur_q <= nxt;
    end

    assign bank_q[b] = cur_q;
  end

  assign cp_ns = bank_q[BANK_NS];
  assign cp_s  = bank_q[BANK_S];

endmodule

// File: rtl/cfgbank_resp.sv
module cfgbank_resp
  import cfgbank_pkg::*;
#(
  parameter int IRQ_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_any,
  input  logic             acc_deny,
  input  logic             rd_ok,
  input  word_t            rd_word,
  input  logic             wr_trig,
  input  logic [IRQ_W-1:0] trig_num,
  output logic             rsp_valid,
  output word_t            rsp_rdata,
  output logic             rsp_err,
  output logic             trig_valid,
  output logic [IRQ_W-1:0] trig_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      trig_valid <= 1'b0;
      trig_irq   <= '0;
    end else begin
      rsp_valid  <= acc_any;
      rsp_err    <= acc_deny;
      rsp_rdata  <= rd_ok ? rd_word : '0;
      trig_valid <= wr_trig;
      trig_irq   <= wr_trig ? trig_num : '0;
    end
  end

endmodule

// File: rtl/sec_cfg_ctrl.sv
module sec_cfg_ctrl
  import cfgbank_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                IRQ_W      = 9,
  parameter bit                V8_PROFILE = 1'b1,
  parameter logic [ADDR_W-1:0] CFG_OFS    = 12'hD14,
  parameter logic [ADDR_W-1:0] HND_OFS    = 12'hD24,
  parameter logic [ADDR_W-1:0] TRIG_OFS   = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_secure,
  input  logic              bus_user,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_err,
  output logic              trig_valid,
  output logic [IRQ_W-1:0]  trig_irq
);

  // named internal events, also observed by the checker
  logic  acc_any, acc_ok, acc_deny;
  logic  wr_cfg, wr_hnd, wr_trig, rd_ok;
  logic  sel_usr_trig;
  logic  mm_active_q;
  word_t cp_ns, cp_s;
  word_t sel_copy, rd_word;

  assign sel_copy     = bus_secure ? cp_s : cp_ns;
  assign sel_usr_trig = sel_copy[F_USR_TRIG];

  cfgbank_gate #(
    .ADDR_W  (ADDR_W),
    .TRIG_OFS(TRIG_OFS)
  ) u_gate (
    .strobe_wr   (bus_wr),
    .strobe_rd   (bus_rd),
    .addr        (bus_addr),
    .user        (bus_user),
    .sel_usr_trig(sel_usr_trig),
    .acc_any     (acc_any),
    .acc_ok      (acc_ok),
    .acc_deny    (acc_deny)
  );

  assign wr_cfg  = acc_ok & bus_wr & (bus_addr == CFG_OFS);
  assign wr_hnd  = acc_ok & bus_wr & (bus_addr == HND_OFS);
  assign wr_trig = acc_ok & bus_wr & (bus_addr == TRIG_OFS);
  assign rd_ok   = acc_ok & bus_rd & ~bus_wr;

  cfgbank_store #(
    .V8_PROFILE(V8_PROFILE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cfg   (wr_cfg),
    .wr_secure(bus_secure),
    .wdata    (bus_wdata),
    .cp_ns    (cp_ns),
    .cp_s     (cp_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mm_active_q <= 1'b0;
    else if (wr_hnd) mm_active_q <= bus_wdata[0];
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == CFG_OFS)      rd_word = cfg_view(sel_copy, cp_ns);
    else if (bus_addr == HND_OFS) rd_word = word_t'(mm_active_q);
  end

  cfgbank_resp #(
    .IRQ_W(IRQ_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_any   (acc_any),
    .acc_deny  (acc_deny),
    .rd_ok     (rd_ok),
    .rd_word   (rd_word),
    .wr_trig   (wr_trig),
    .trig_num  (bus_wdata[IRQ_W-1:0]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .trig_valid(trig_valid),
    .trig_irq  (trig_irq)
  );

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter bit                V8_PROFILE = 1'b1,
  parameter logic [ADDR_W-1:0] TRIG_OFS   = 12'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_secure,
  input logic              bus_user,
  input logic              rsp_valid,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic              rsp_err,
  input logic              trig_valid,
  input logic              acc_deny,
  input logic              mm_active_q,
  input word_t             cp_ns,
  input word_t             cp_s
);

  a_r6_user_other_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_user && (bus_wr || bus_rd) && bus_addr != TRIG_OFS) |=> (rsp_valid && rsp_err));

  a_r6_denied_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |=> ($stable(cp_ns) && $stable(cp_s) && $stable(mm_active_q) && !trig_valid));

  a_r7_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_user && bus_wr && bus_addr == TRIG_OFS &&
     !(bus_secure ? cp_s[F_USR_TRIG] : cp_ns[F_USR_TRIG])) |=> (rsp_err && !trig_valid));

  a_r3_secure_copy_no_shared: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_s[F_FIGN]);

  a_r5_forced_ones: assert property (@(posedge clk) disable iff (!rst_n)
    V8_PROFILE |-> (cp_ns[F_THR_ANY] && cp_ns[F_STK] && cp_s[F_THR_ANY] && cp_s[F_STK]));

  a_r8_trig_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> ($past(bus_wr) && $past(bus_addr) == TRIG_OFS && !$past(acc_deny)));

  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !rsp_valid);

  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

endmodule

bind sec_cfg_ctrl cfgbank_chk #(
  .ADDR_W    (ADDR_W),
  .V8_PROFILE(V8_PROFILE),
  .TRIG_OFS  (TRIG_OFS)
) u_chk (.*);

// File: tb/tb_sec_cfg_ctrl.sv
module tb_sec_cfg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CFG  = 12'hD14;
  localparam logic [11:0] A_HND  = 12'hD24;
  localparam logic [11:0] A_TRIG = 12'hF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0, bus_user = 1'b0;
  logic        rsp_valid, rsp_err, trig_valid;
  logic [31:0] rsp_rdata;
  logic [8:0]  trig_irq;

  sec_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure), .bus_user(bus_user),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .trig_valid(trig_valid), .trig_irq(trig_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          err;
    logic [31:0] rdata;
    bit          tv;
    logic [8:0]  irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model of the two copies and the handler flag
  logic [31:0] m_ns = 32'h201;
  logic [31:0] m_s  = 32'h201;
  bit          m_mm = 0;

  function automatic logic [31:0] shape(input logic [31:0] w);
    // writable: 0,1,3,4,8,9 ; forced one: 0 and 9 (default v8 profile)
    return (w & 32'h0000_031B) | 32'h0000_0201;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
  endtask

  task automatic acc(input bit wr, input bit rd, input logic [11:0] a,
                     input logic [31:0] d, input bit sec, input bit usr,
                     input string tag);
    exp_t e;
    bit allowed;
    bit is_write;
    logic [31:0] own;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    bus_secure = sec; bus_user = usr;
    own = sec ? m_s : m_ns;
    is_write = wr;
    allowed = !usr || (a == A_TRIG && own[1]);
    e.tag = tag;
    e.err = !allowed;
    e.rdata = '0;
    e.tv = allowed && is_write && a == A_TRIG;
    e.irq = e.tv ? d[8:0] : 9'd0;
    if (allowed && !is_write && rd) begin
      if (a == A_CFG) e.rdata = {own[31:9], m_ns[8], own[7:0]};
      else if (a == A_HND) e.rdata = {31'd0, m_mm};
    end
    if (allowed && is_write) begin
      if (a == A_CFG) begin
        if (sec) begin
          m_ns[8] = shape(d) >> 8;
          m_s = shape(d) & 32'hFFFF_FEFF;
        end else begin
          m_ns = shape(d);
        end
      end else if (a == A_HND) begin
        m_mm = d[0];
      end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_user = 0; bus_secure = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          n_cmp++;
          fail_line("R10", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          n_cmp++;
          if (rsp_err !== e.err)       fail_line(e.tag, "err", 32'(rsp_err), 32'(e.err));
          if (rsp_rdata !== e.rdata)   fail_line(e.tag, "rdata", rsp_rdata, e.rdata);
          if (trig_valid !== e.tv)     fail_line(e.tag, "trig_valid", 32'(trig_valid), 32'(e.tv));
          if (trig_irq !== e.irq)      fail_line(e.tag, "trig_irq", 32'(trig_irq), 32'(e.irq));
        end
      end else if (trig_valid) begin
        n_cmp++;
        fail_line("R8", "stray trigger pulse", 32'd1, 32'd0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || trig_valid !== 1'b0)
      fail_line("R10", "reset outputs", {29'd0, rsp_valid, rsp_err, trig_valid}, 32'd0);
    rst_n = 1'b1;
    idle(1);

    // R5 reset values, R1 both copies
    acc(0, 1, A_CFG, 0, 1, 0, "R5_reset_s");
    acc(0, 1, A_CFG, 0, 0, 0, "R5_reset_ns");

    // R4 writable mask, R2 shared bit seen by Secure read
    acc(1, 0, A_CFG, 32'hFFFF_FFFF, 0, 0, "R4_ns_write_all");
    acc(0, 1, A_CFG, 0, 0, 0, "R4_ns_readback");
    acc(0, 1, A_CFG, 0, 1, 0, "R2_secure_sees_shared");

    // R3 Secure write clears shared bit, NS other bits kept
    acc(1, 0, A_CFG, 32'h0000_0002, 1, 0, "R3_sec_write_clear");
    acc(0, 1, A_CFG, 0, 1, 0, "R3_sec_readback");
    acc(0, 1, A_CFG, 0, 0, 0, "R3_ns_kept");
    acc(1, 0, A_CFG, 32'h0000_0118, 1, 0, "R3_sec_write_set");
    acc(0, 1, A_CFG, 0, 1, 0, "R2_sec_merge");
    acc(0, 1, A_CFG, 0, 0, 0, "R2_ns_shared");

    // R5 forced ones on a zero write; R1 worlds differ
    acc(1, 0, A_CFG, 32'h0, 0, 0, "R5_ns_write_zero");
    acc(0, 1, A_CFG, 0, 0, 0, "R5_forced_readback");
    acc(0, 1, A_CFG, 0, 1, 0, "R1_secure_separate");

    // R6 unprivileged access elsewhere is refused and has no effect
    acc(0, 1, A_CFG, 0, 0, 1, "R6_user_read");
    acc(1, 0, A_CFG, 32'hFFFF, 0, 1, "R6_user_write");
    acc(1, 0, A_HND, 32'h1, 1, 1, "R6_user_hnd_write");
    acc(0, 1, A_CFG, 0, 0, 0, "R6_unchanged_ns");
    acc(0, 1, A_HND, 0, 0, 0, "R6_unchanged_hnd");

    // R7 trigger gate per world
    acc(1, 0, A_TRIG, 32'h0AB, 0, 1, "R7_ns_denied");
    acc(1, 0, A_TRIG, 32'h0AB, 1, 1, "R7_sec_denied");
    acc(1, 0, A_CFG, 32'h0000_0002, 1, 0, "R7_enable_sec");
    acc(1, 0, A_TRIG, 32'h1AB, 1, 1, "R7_sec_allowed");
    acc(1, 0, A_TRIG, 32'h1AB, 0, 1, "R7_ns_still_denied");
    acc(0, 1, A_TRIG, 0, 1, 1, "R7_sec_user_read_ok");
    idle(2);

    // R8 privileged triggers, back to back, with idle gaps
    acc(1, 0, A_TRIG, 32'hFFFF_F005, 0, 0, "R8_trig_a");
    acc(1, 0, A_TRIG, 32'h0000_01FF, 1, 0, "R8_trig_b");
    acc(1, 1, A_TRIG, 32'h0000_0100, 0, 0, "R10_both_strobes");
    idle(3);

    // R9 handler flag
    acc(1, 0, A_HND, 32'h1, 0, 0, "R9_set");
    acc(0, 1, A_HND, 0, 1, 0, "R9_read_set");
    acc(1, 0, A_HND, 32'hFFFF_FFFE, 1, 0, "R9_clear");
    acc(0, 1, A_HND, 0, 0, 0, "R9_read_clear");

    // R10 unmapped read returns zero without error
    acc(0, 1, 12'h100, 0, 0, 0, "R10_unmapped");
    acc(1, 0, 12'h104, 32'hDEAD_BEEF, 1, 0, "R10_unmapped_write");
    acc(0, 1, A_CFG, 0, 1, 0, "R10_cfg_after");
    idle(4);

    n_cmp++;
    if (q.size() != 0) fail_line("R10", "responses missing", q.size(), 32'd0);
    summary();
  end

endmodule